// File: doc/BRIEF.md
# Synchronous Serial Clock-Stretch Controller

This block is the receive-side controller for a two-wire synchronous serial port. One wire carries the clock and the other carries data. Both wires are open-drain with pull-ups outside the block, so the block only ever pulls a wire low or lets it go. It samples both wires through synchronizers. It watches for two bus events: a start-like event, where data falls while the clock is high, and a stop-like event, where data rises while the clock is high. It records each event in a sticky flag that can raise an interrupt.

A host reaches the block through a small register interface. The host can enable the port and choose between two kinds of clock stretching. In the first kind, the clock wire is held low after every clock falling edge. In the second kind, it is held low only after the first falling edge that follows a start-like event. While the clock is held, a wait-status bit reads 1. The host ends the hold by writing the transmit buffer. The buffer bit sets the data wire first, and the clock wire is let go one cycle later, so data is stable before the clock can rise.

Register map (2-bit address, 8-bit data): address 0 is control, address 1 is the start flag, address 2 is the stop flag, and address 3 is the transmit buffer.

Top module: `sync_clkstretch_ctrl`

## Requirements
- R1: While control bit 0 (port enable) is 1, `dt_drive_low_o` equals the inverse of transmit-buffer bit 0, whose reset value is 1. `ck_drive_low_o` is 1 only during a hold. Both outputs are pull-low enables, so neither wire is ever driven high.
- R2: With control bit 1 (always-stretch) set, a falling edge on the clock wire sets `ck_drive_low_o` within 4 cycles. It stays set even after the external clock source lets the wire rise again.
- R3: Control-register bit 5 (wait status, read-only) reads 1 while the clock is held and 0 otherwise.
- R4: A write to address 3 updates the data pull at the write edge. The clock is let go one cycle after that edge, and the wait status then reads 0.
- R5: With control bit 2 (start-gated stretch) set and bit 1 clear, a clock falling edge is held only if a start-like event occurred since the last hold. A fall with no such event causes no hold.
- R6: A data falling edge while the clock is high sets bit 0 at address 1. The flag stays set until a read of address 1 clears it.
- R7: A data rising edge while the clock is high sets bit 0 at address 2. Writing 1 to bit 0 of that address clears it, and writing 0 has no effect.
- R8: `irq_o` is the OR of (start flag AND control bit 3) and (stop flag AND control bit 4).
- R9: Clearing control bit 0 lets both wires go at once, aborts any hold, and makes the wait status read 0.
- R10: While control bit 0 is 0, bus events set no flag and cause no hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (clears a flag when reading one) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| ck_line_i | input | 1 | Sampled level of the clock wire |
| dt_line_i | input | 1 | Sampled level of the data wire |
| ck_drive_low_o | output | 1 | Pull the clock wire low |
| dt_drive_low_o | output | 1 | Pull the data wire low |
| irq_o | output | 1 | Interrupt request |

## Verification
Register writes take effect at the edge they are sampled on. A flag, the enable gate and the data pull are therefore visible one cycle after the write. Clock release follows one cycle after that. The bench samples 1 ns after each edge and waits the extra cycle before checking the clock pull. A change on a wire passes through two synchronizer stages, one edge register and one state register, so every wire-driven result is checked four cycles after the stimulus. Read data is combinational and is captured in the cycle the read strobe is high, before the clearing edge.

// File: rtl/sstretch_pkg.sv
// Shared definitions for the clock-stretch controller.
// Assumes a 2-bit register address and an 8-bit register data bus.
package sstretch_pkg;
    localparam int REG_ADDR_W = 2;
    localparam int REG_DATA_W = 8;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        A_CTRL  = 2'd0,
        A_START = 2'd1,
        A_STOP  = 2'd2,
        A_TXBUF = 2'd3
    } reg_addr_e;

    // Control register bits, lowest bit first: en, always_on, cond, ie_start, ie_stop
    typedef struct packed {
        logic ie_stop;
        logic ie_start;
        logic cond;
        logic always_on;
        logic en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int HOLD_BIT = 5;
endpackage

// File: rtl/line_sync.sv
// Multi-stage synchronizer for one wire input.
// Assumes the wire idles high, so every stage resets to 1.
module line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: move the sampled value one stage along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= 1'b1;
                else if (g == 0) stage_q[g] <= async_i;
                else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cond_detect.sv
// Finds clock falling edges and start-like and stop-like events on the synchronized wires.
// Assumes synchronized inputs. An event needs the clock high in both the previous and the current sample.
module cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ck_s,
    input  logic dt_s,
    output logic ck_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic ck_q, dt_q;

    // Purpose: keep the previous synchronized levels, even while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_q <= 1'b1;
            dt_q <= 1'b1;
        end else begin
            ck_q <= ck_s;
            dt_q <= dt_s;
        end
    end

    // Purpose: decode the edges, gated by the port enable
    always_comb begin
        ck_fall   = en && ck_q && !ck_s;
        start_evt = en && ck_q && ck_s && dt_q && !dt_s;
        stop_evt  = en && ck_q && ck_s && !dt_q && dt_s;
    end
endmodule

// File: rtl/hold_ctrl.sv
// Clock-hold state: takes a hold on a clock falling edge (always, or once after a start-like event)
// and lets go one cycle after a buffer write, so data is set up before the clock is let go.
// Assumes ck_fall and start_evt are already gated by en.
module hold_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic always_on,
    input  logic cond,
    input  logic ck_fall,
    input  logic start_evt,
    input  logic buf_wr,
    output logic hold_o
);
    logic hold_q, rel_pend, armed;
    logic take;

    // Purpose: decide whether this clock fall starts a hold
    always_comb begin
        take = ck_fall && !hold_q && !rel_pend && (always_on || (cond && armed));
    end

    // Purpose: arm, hold and release state, all cleared when the port is disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hold_q   <= 1'b0;
            rel_pend <= 1'b0;
            armed    <= 1'b0;
        end else begin
            if (start_evt) armed <= 1'b1;
            else if (take) armed <= 1'b0;
            rel_pend <= buf_wr && hold_q;
            if (rel_pend) hold_q <= 1'b0;
            else if (take) hold_q <= 1'b1;
        end
    end

    assign hold_o = hold_q;

    // R2
    always_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && always_on && ck_fall && !hold_q && !rel_pend) |=> hold_q);
    // R4
    release_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && buf_wr) |=> ##1 !hold_q);
    // R9
    disable_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !hold_q);
    // R5
    hold_needs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_q) |-> $past(ck_fall));
endmodule

// File: rtl/host_regs.sv
// Host register file: control, two sticky condition flags, the transmit buffer, read mux and interrupt.
// Assumes single-cycle strobes. A flag set beats a clear in the same cycle.
module host_regs
    import sstretch_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic                  rd,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [REG_DATA_W-1:0] wdata,
    input  logic                  start_evt,
    input  logic                  stop_evt,
    input  logic                  hold,
    output ctrl_t                 ctrl,
    output logic                  txbit,
    output logic                  buf_wr,
    output logic [REG_DATA_W-1:0] rdata,
    output logic                  irq
);
    logic start_flag, stop_flag;
    logic clr_start, clr_stop;
    logic unused_wbits;

    assign unused_wbits = ^wdata[REG_DATA_W-1:CTRL_W];

    // Purpose: decode host strobes
    always_comb begin
        buf_wr    = wr && (addr == A_TXBUF);
        clr_start = (rd && addr == A_START) || (wr && addr == A_START && wdata[0]);
        clr_stop  = (rd && addr == A_STOP)  || (wr && addr == A_STOP  && wdata[0]);
    end

    // Purpose: control and transmit-buffer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            txbit <= 1'b1;
        end else begin
            if (wr && addr == A_CTRL) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (buf_wr) txbit <= wdata[0];
        end
    end

    // Purpose: sticky condition flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_flag <= 1'b0;
            stop_flag  <= 1'b0;
        end else begin
            if (start_evt) start_flag <= 1'b1;
            else if (clr_start) start_flag <= 1'b0;
            if (stop_evt) stop_flag <= 1'b1;
            else if (clr_stop) stop_flag <= 1'b0;
        end
    end

    // Purpose: read mux
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[CTRL_W-1:0] = ctrl;
                rdata[HOLD_BIT]   = hold;
            end
            A_START: rdata[0] = start_flag;
            A_STOP:  rdata[0] = stop_flag;
            default: rdata[0] = txbit;
        endcase
    end

    // Purpose: interrupt from the enabled flags
    assign irq = (start_flag && ctrl.ie_start) || (stop_flag && ctrl.ie_stop);

    // R6
    start_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> start_flag);
    // R6
    start_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_flag && !clr_start) |=> start_flag);
    // R7
    stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_flag && !clr_stop) |=> stop_flag);
endmodule

// File: rtl/sync_clkstretch_ctrl.sv
// Top of the clock-stretch controller: synchronizers, event detect, hold state and host registers.
// Assumes the wires have outside pull-ups. The outputs are pull-low enables only.
module sync_clkstretch_ctrl
    import sstretch_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [REG_DATA_W-1:0] reg_rdata,
    input  logic                  ck_line_i,
    input  logic                  dt_line_i,
    output logic                  ck_drive_low_o,
    output logic                  dt_drive_low_o,
    output logic                  irq_o
);
    logic  ck_s, dt_s, ck_fall, start_evt, stop_evt, hold, txbit, buf_wr;
    ctrl_t ctrl;

    line_sync #(.STAGES(SYNC_STAGES)) u_ck_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ck_line_i), .sync_o(ck_s));
    line_sync #(.STAGES(SYNC_STAGES)) u_dt_sync (
        .clk(clk), .rst_n(rst_n), .async_i(dt_line_i), .sync_o(dt_s));

    cond_detect u_det (
        .clk(clk), .rst_n(rst_n), .en(ctrl.en), .ck_s(ck_s), .dt_s(dt_s),
        .ck_fall(ck_fall), .start_evt(start_evt), .stop_evt(stop_evt));

    hold_ctrl u_hold (
        .clk(clk), .rst_n(rst_n), .en(ctrl.en), .always_on(ctrl.always_on),
        .cond(ctrl.cond), .ck_fall(ck_fall), .start_evt(start_evt),
        .buf_wr(buf_wr), .hold_o(hold));

    host_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .start_evt(start_evt), .stop_evt(stop_evt),
        .hold(hold), .ctrl(ctrl), .txbit(txbit), .buf_wr(buf_wr),
        .rdata(reg_rdata), .irq(irq_o));

    // Purpose: pull-low enables, cut off at once when the port is disabled
    always_comb begin
        ck_drive_low_o = ctrl.en && hold;
        dt_drive_low_o = ctrl.en && !txbit;
    end

    // R10
    no_event_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |-> !(start_evt || stop_evt || ck_fall));
endmodule

// File: tb/sim_sync_clkstretch_ctrl.sv
module sim_sync_clkstretch_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       ext_ck = 1'b1, ext_dt = 1'b1;
    logic       ck_drv, dt_drv, irq;
    wire        ck_line = ext_ck & ~ck_drv;
    wire        dt_line = ext_dt & ~dt_drv;
    int         checks = 0, failures = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    sync_clkstretch_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ck_line_i(ck_line), .dt_line_i(dt_line),
        .ck_drive_low_o(ck_drv), .dt_drive_low_o(dt_drv), .irq_o(irq));

    function automatic logic [7:0] ctrl_val(bit en, bit alw, bit cnd, bit ies, bit iep);
        return {3'b000, iep, ies, cnd, alw, en};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(); @(posedge clk); #1; endtask
    task automatic waitn(int n); repeat (n) tick(); endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        logic [7:0] v;
        bit exp_s, exp_p, prev_dt;
        void'($urandom(32'd4321));
        waitn(3);
        rst_n = 1'b1;
        tick();
        // reset state
        check("R1 reset ck drive", {7'd0, ck_drv}, 8'd0);
        check("R1 reset dt drive", {7'd0, dt_drv}, 8'd0);
        check("R8 reset irq", {7'd0, irq}, 8'd0);
        rd(2'd0, v); check("R3 reset ctrl", v, 8'd0);

        // R1: enable, data pull follows buffer bit
        wr(2'd0, ctrl_val(1, 0, 0, 0, 0));
        check("R1 dt released with buffer 1", {7'd0, dt_drv}, 8'd0);
        wr(2'd3, 8'd0);
        check("R1 dt pulled with buffer 0", {7'd0, dt_drv}, 8'd1);
        check("R1 no ck pull without hold", {7'd0, ck_drv}, 8'd0);
        wr(2'd3, 8'd1);
        check("R1 dt released again", {7'd0, dt_drv}, 8'd0);
        waitn(4);
        rd(2'd1, v); rd(2'd2, v);

        // R2/R3/R4: unconditional stretching
        wr(2'd0, ctrl_val(1, 1, 0, 0, 0));
        ext_ck = 1'b0; waitn(4);
        check("R2 ck held after fall", {7'd0, ck_drv}, 8'd1);
        ext_ck = 1'b1; waitn(2);
        check("R2 ck wire stays low", {7'd0, ck_line}, 8'd0);
        rd(2'd0, v); check("R3 wait status set", {7'd0, v[5]}, 8'd1);
        wr(2'd3, 8'd0);
        check("R4 data updated at write", {7'd0, dt_drv}, 8'd1);
        check("R4 ck still held at write", {7'd0, ck_drv}, 8'd1);
        tick();
        check("R4 ck released one cycle later", {7'd0, ck_drv}, 8'd0);
        rd(2'd0, v); check("R3 wait status clear", {7'd0, v[5]}, 8'd0);
        wr(2'd3, 8'd1); waitn(4);

        // R5: start-gated stretching
        wr(2'd0, ctrl_val(1, 0, 1, 0, 0));
        rd(2'd1, v); rd(2'd2, v);
        ext_ck = 1'b0; waitn(4);
        check("R5 no hold without start", {7'd0, ck_drv}, 8'd0);
        ext_ck = 1'b1; waitn(4);
        ext_dt = 1'b0; waitn(4);
        ext_ck = 1'b0; waitn(4);
        check("R5 hold after start", {7'd0, ck_drv}, 8'd1);
        ext_dt = 1'b1; waitn(2);
        wr(2'd3, 8'd1); tick();
        check("R5 released", {7'd0, ck_drv}, 8'd0);
        ext_ck = 1'b1; waitn(4);
        ext_ck = 1'b0; waitn(4);
        check("R5 second fall not held", {7'd0, ck_drv}, 8'd0);
        ext_ck = 1'b1; waitn(4);
        // R6: start flag sticky, read clears
        rd(2'd1, v); check("R6 start flag set", v, 8'd1);
        rd(2'd1, v); check("R6 start flag cleared by read", v, 8'd0);

        // R7/R8: stop flag and interrupt
        rd(2'd2, v);
        wr(2'd0, ctrl_val(1, 0, 0, 0, 1));
        ext_dt = 1'b0; waitn(4);
        check("R8 start masked", {7'd0, irq}, 8'd0);
        ext_dt = 1'b1; waitn(4);
        check("R8 stop irq", {7'd0, irq}, 8'd1);
        wr(2'd2, 8'd0); tick();
        check("R7 write 0 keeps stop flag", {7'd0, irq}, 8'd1);
        wr(2'd2, 8'd1);
        check("R7 write 1 clears stop flag", {7'd0, irq}, 8'd0);
        wr(2'd0, ctrl_val(1, 0, 0, 1, 0));
        check("R8 start flag with enable", {7'd0, irq}, 8'd1);
        rd(2'd1, v);
        check("R8 irq drops after read", {7'd0, irq}, 8'd0);

        // R9: disable during hold
        wr(2'd0, ctrl_val(1, 1, 0, 0, 0));
        wr(2'd3, 8'd0);
        ext_ck = 1'b0; waitn(4);
        check("R9 hold before disable", {7'd0, ck_drv}, 8'd1);
        wr(2'd0, 8'd0);
        check("R9 ck released at once", {7'd0, ck_drv}, 8'd0);
        check("R9 dt released at once", {7'd0, dt_drv}, 8'd0);
        tick();
        rd(2'd0, v); check("R9 wait status clear", {7'd0, v[5]}, 8'd0);
        ext_ck = 1'b1; waitn(4);

        // R10: events ignored while disabled
        ext_dt = 1'b0; waitn(4);
        ext_ck = 1'b0; waitn(4);
        check("R10 no hold while disabled", {7'd0, ck_drv}, 8'd0);
        ext_ck = 1'b1; waitn(4);
        ext_dt = 1'b1; waitn(4);
        wr(2'd3, 8'd1);
        wr(2'd0, ctrl_val(1, 0, 0, 1, 1));
        check("R10 no irq after re-enable", {7'd0, irq}, 8'd0);
        rd(2'd1, v); check("R10 no start flag", v, 8'd0);
        rd(2'd2, v); check("R10 no stop flag", v, 8'd0);

        // Random data toggling with the clock high, R6/R7/R8 against a bench model
        exp_s = 0; exp_p = 0; prev_dt = 1;
        for (int i = 0; i < 80; i++) begin
            bit nd;
            nd = 1'($urandom % 2);
            ext_dt = nd;
            if (prev_dt && !nd) exp_s = 1;
            if (!prev_dt && nd) exp_p = 1;
            prev_dt = nd;
            waitn(4);
            check("R8 random irq", {7'd0, irq}, {7'd0, exp_s | exp_p});
            if ($urandom % 3 == 0) begin
                rd(2'd1, v); check("R6 random start flag", v, {7'd0, exp_s}); exp_s = 0;
            end
            if ($urandom % 3 == 0) begin
                rd(2'd2, v); check("R7 random stop flag", v, {7'd0, exp_p}); exp_p = 0;
            end
        end
        done = 1'b1;
        report();
    end
endmodule